// File: doc/BRIEF.md
# Configurable External Bus Cycle Generator

This block turns single requests from an internal master into timed cycles on an external asynchronous memory and I/O bus. The 24-bit address space is divided into eight areas selected by the top three address bits. Each area has its own settings: a 16-bit or 8-bit data bus, a short or long access, a number of programmed wait states, an early or normal read strobe release, and optional chip-select extension states that surround the access. The block drives the address, one active-low chip select per area, an address strobe, a read strobe, upper and lower write strobes and the data bus direction. It captures read data and raises a one-cycle done pulse when the request is finished.

The block runs on a clock at twice the external bus state rate. One bus state is two clock ticks, so strobe edges can fall in the middle of a state. A word access to an 8-bit area becomes two byte cycles, even address first, with a single done at the end. Area settings are written through a small write port and take effect only while the bus is idle.

The control is a four-state machine. `ST_IDLE` waits for a request. `ST_PRE` is the two-tick leading extension. `ST_ACC` is the access proper. `ST_POST` is the two-tick trailing extension. The transitions are as follows. Idle to pre on a request to an extended area, or idle to access otherwise. Pre to access after two ticks. At the last access tick, access goes to post if the area is extended. Otherwise it goes back to access for the odd byte of a split word, or to idle with done. After two ticks, post goes to pre for the odd byte of a split word, or to idle with done.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: After reset no chip select, address strobe, read strobe or write strobe is active, `bus_doe` and `done` are low and `req_ready` is high. Every area starts as a 16-bit, long-access area with 7 wait states, normal read release and no extension.
- R2: The area is `addr[23:21]`. Only that area's chip select is low, and it stays low on every tick from the first bus tick to the last, extension ticks included.
- R3: The access part lasts 4 ticks when `cfg_wdata[1]`=0 (short access), whatever the wait field. It lasts 2*(3+W) ticks when `cfg_wdata[1]`=1, where W=`cfg_wdata[4:2]`. `cfg_wdata[0]`=1 selects an 8-bit area.
- R4: The read strobe is low from the second access tick to the last access tick. With `cfg_wdata[5]`=1 it releases one tick earlier. Read data is taken on the last tick the strobe is low.
- R5: With `cfg_wdata[6]`=1, two ticks come before and two ticks come after each access. In these ticks chip select, address strobe and address are driven, and no read or write strobe is active.
- R6: On a 16-bit area, `req_be[1]` selects the even byte on bits 15:8 with `bus_hwr_n`. `req_be[0]` selects the odd byte on bits 7:0 with `bus_lwr_n`. Lanes that are not enabled read back as zero.
- R7: On an 8-bit area all data moves on bits 15:8 and `bus_lwr_n` never falls. A single byte takes one cycle, and its byte lane in `req_wdata` and `rdata` follows `req_be`.
- R8: A word (`req_be`=11) on an 8-bit area runs as two full cycles, the even address then the odd address. `done` is raised once, after the second cycle.
- R9: `done` is a one-cycle pulse after the last bus tick, and `rdata` is valid in that cycle. `req_ready` is low whenever a bus cycle is in progress.
- R10: A configuration write is ignored while a bus cycle is in progress. It is applied when the bus is idle.
- R11: During a write access `bus_doe` is high, and the byte seen with a write strobe matches the requested lane data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus state rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_be | input | 2 | Byte enables: bit 1 even byte, bit 0 odd byte |
| req_wdata | input | 16 | Write data, even byte in bits 15:8 |
| done | output | 1 | End-of-request pulse |
| rdata | output | 16 | Read data, valid with done |
| cfg_we | input | 1 | Area setting write strobe |
| cfg_area | input | 3 | Area being written |
| cfg_wdata | input | 7 | {ext, early, wait[2:0], long, narrow} |
| bus_addr | output | 24 | External address |
| bus_cs_n | output | 8 | Active-low chip select per area |
| bus_as_n | output | 1 | Active-low address strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_hwr_n | output | 1 | Active-low upper-byte write strobe |
| bus_lwr_n | output | 1 | Active-low lower-byte write strobe |
| bus_dout | output | 16 | Data driven to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Data from the bus |

## Verification
The bench runs a short-access area that has a nonzero wait field. A design that applied the waits anyway would stretch the access well past four ticks. It also runs early-release reads, where an off-by-one strobe window or a capture on the wrong tick would show up as a wrong strobe length or stale data. It runs extended areas, where a strobe leaking into the extension ticks would lengthen the strobe count, and split words on 8-bit areas, where a second done, a wrong byte order or a missing odd address would break the byte signature. A configuration write issued in the middle of a long cycle must leave the next access to that area with its old short timing.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int WAIT_W = 3;

    // Per-area settings, packed in the order of the setting write word
    typedef struct packed {
        logic              ext;     // bit 6: extension ticks around access
        logic              early;   // bit 5: read strobe released a tick early
        logic [WAIT_W-1:0] waits;   // bits 4:2: programmed wait states
        logic              slow;    // bit 1: long (3-state) access
        logic              narrow;  // bit 0: 8-bit data bus
    } area_cfg_t;

    localparam area_cfg_t CFG_RESET = '{
        ext: 1'b0, early: 1'b0, waits: {WAIT_W{1'b1}}, slow: 1'b1, narrow: 1'b0
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACC,
        ST_POST
    } bus_state_e;

endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
    import ebc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  area_cfg_t        wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output area_cfg_t        rd_val
);

    localparam int N_AREAS = 1 << SEL_W;

    area_cfg_t regs [N_AREAS];

    for (genvar g = 0; g < N_AREAS; g++) begin : g_area
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= CFG_RESET;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs[g] <= wr_val;
            end
        end
    end

    assign rd_val = regs[rd_sel];

endmodule

// File: rtl/ebc_timing.sv
module ebc_timing
    import ebc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              slow,
    input  logic              early,
    input  logic [WAIT_W-1:0] waits,
    output logic [CNT_W-1:0]  acc_last,
    output logic [CNT_W-1:0]  rd_last
);

    int n_states;

    always_comb begin
        n_states = slow ? (3 + int'(waits)) : 2;
        acc_last = CNT_W'(2 * n_states - 1);
        rd_last  = early ? (acc_last - CNT_W'(1)) : acc_last;
    end

endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes (
    input  logic        narrow,
    input  logic [1:0]  be,
    input  logic        phase,
    input  logic [15:0] wdata,
    input  logic [15:0] din,
    input  logic [15:0] rdata_q,
    output logic        hi_en,
    output logic        lo_en,
    output logic [15:0] dout,
    output logic [15:0] rdata_next
);

    logic use_odd;

    always_comb begin
        // on a narrow bus, the odd byte is the second half of a word or an odd single byte
        use_odd = (be == 2'b11) ? phase : !be[1];
        if (narrow) begin
            hi_en      = 1'b1;
            lo_en      = 1'b0;
            dout       = {use_odd ? wdata[7:0] : wdata[15:8], 8'h00};
            rdata_next = use_odd ? {rdata_q[15:8], din[15:8]}
                                 : {din[15:8], rdata_q[7:0]};
        end else begin
            hi_en      = be[1];
            lo_en      = be[0];
            dout       = wdata;
            rdata_next = {be[1] ? din[15:8] : rdata_q[15:8],
                          be[0] ? din[7:0]  : rdata_q[7:0]};
        end
    end

endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int AREA_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic [1:0]                  req_be,
    input  logic [15:0]                 req_wdata,
    output logic                        done,
    output logic [15:0]                 rdata,
    input  logic                        cfg_we,
    input  logic [AREA_BITS-1:0]        cfg_area,
    input  logic [$bits(area_cfg_t)-1:0] cfg_wdata,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [(1<<AREA_BITS)-1:0]   bus_cs_n,
    output logic                        bus_as_n,
    output logic                        bus_rd_n,
    output logic                        bus_hwr_n,
    output logic                        bus_lwr_n,
    output logic [15:0]                 bus_dout,
    output logic                        bus_doe,
    input  logic [15:0]                 bus_din
);

    localparam int N_AREAS   = 1 << AREA_BITS;
    localparam int MAX_TICKS = 2 * (2 + (1 << WAIT_W));
    localparam int CNT_W     = $clog2(MAX_TICKS);

    bus_state_e              state, state_d;
    logic [CNT_W-1:0]        cnt, cnt_d;
    logic                    phase_q, phase_d;
    logic                    fin;
    area_cfg_t               cur_cfg, sel_cfg;
    logic [ADDR_W-1:0]       addr_q;
    logic                    write_q;
    logic [1:0]              be_q;
    logic [15:0]             wdata_q;
    logic [15:0]             rdata_q, rdata_next;
    logic                    done_q;
    logic [CNT_W-1:0]        acc_last, rd_last;
    logic                    hi_en, lo_en;
    logic                    accept, idle, split_more, strobe_win;
    logic [AREA_BITS-1:0]    area_q;

    assign idle       = (state == ST_IDLE);
    assign accept     = idle && req_valid;
    assign area_q     = addr_q[ADDR_W-1 -: AREA_BITS];
    assign split_more = cur_cfg.narrow && (be_q == 2'b11) && !phase_q;

    ebc_cfg_regs #(.SEL_W(AREA_BITS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we && idle),
        .wr_sel (cfg_area),
        .wr_val (area_cfg_t'(cfg_wdata)),
        .rd_sel (req_addr[ADDR_W-1 -: AREA_BITS]),
        .rd_val (sel_cfg)
    );

    ebc_timing #(.CNT_W(CNT_W)) u_timing (
        .slow     (cur_cfg.slow),
        .early    (cur_cfg.early),
        .waits    (cur_cfg.waits),
        .acc_last (acc_last),
        .rd_last  (rd_last)
    );

    ebc_lanes u_lanes (
        .narrow     (cur_cfg.narrow),
        .be         (be_q),
        .phase      (phase_q),
        .wdata      (wdata_q),
        .din        (bus_din),
        .rdata_q    (rdata_q),
        .hi_en      (hi_en),
        .lo_en      (lo_en),
        .dout       (bus_dout),
        .rdata_next (rdata_next)
    );

    // next state
    always_comb begin
        state_d = state;
        cnt_d   = cnt + CNT_W'(1);
        phase_d = phase_q;
        fin     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_d   = '0;
                phase_d = 1'b0;
                if (accept) state_d = sel_cfg.ext ? ST_PRE : ST_ACC;
            end
            ST_PRE: begin
                if (cnt == CNT_W'(1)) begin
                    state_d = ST_ACC;
                    cnt_d   = '0;
                end
            end
            ST_ACC: begin
                if (cnt == acc_last) begin
                    cnt_d = '0;
                    if (cur_cfg.ext) begin
                        state_d = ST_POST;
                    end else if (split_more) begin
                        phase_d = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (cnt == CNT_W'(1)) begin
                    cnt_d = '0;
                    if (split_more) begin
                        state_d = ST_PRE;
                        phase_d = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            phase_q <= 1'b0;
        end else begin
            state   <= state_d;
            cnt     <= cnt_d;
            phase_q <= phase_d;
        end
    end

    // request capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cfg <= CFG_RESET;
            addr_q  <= '0;
            write_q <= 1'b0;
            be_q    <= 2'b00;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin;
            if (accept) begin
                cur_cfg <= sel_cfg;
                addr_q  <= req_addr;
                write_q <= req_write;
                be_q    <= req_be;
                wdata_q <= req_wdata;
                rdata_q <= '0;
            end else if (state == ST_ACC && !write_q && cnt == rd_last) begin
                rdata_q <= rdata_next;
            end
        end
    end

    // outputs
    always_comb begin
        strobe_win = (state == ST_ACC) && (cnt != '0);
        req_ready  = idle;
        done       = done_q;
        rdata      = rdata_q;
        bus_as_n   = idle;
        bus_cs_n   = '1;
        bus_addr   = '0;
        if (!idle) begin
            bus_cs_n[area_q] = 1'b0;
            bus_addr = {addr_q[ADDR_W-1:1], addr_q[0] | phase_q};
        end
        bus_rd_n  = !(strobe_win && !write_q && cnt <= rd_last);
        bus_hwr_n = !(strobe_win && write_q && hi_en);
        bus_lwr_n = !(strobe_win && write_q && lo_en);
        bus_doe   = (state == ST_ACC) && write_q;
    end

endmodule

// File: rtl/ebc_bus_ctrl_chk.sv
module ebc_bus_ctrl_chk
    import ebc_pkg::*;
#(
    parameter int AREA_BITS = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_ready,
    input logic                      done,
    input logic [(1<<AREA_BITS)-1:0] bus_cs_n,
    input logic                      bus_as_n,
    input logic                      bus_rd_n,
    input logic                      bus_hwr_n,
    input logic                      bus_lwr_n,
    input bus_state_e                state,
    input area_cfg_t                 cur_cfg
);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    // R2
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_hwr_n || !bus_lwr_n) |-> (!bus_as_n && (~bus_cs_n != '0)));

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_hwr_n && bus_lwr_n));

    // R5
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACC) |-> (bus_rd_n && bus_hwr_n && bus_lwr_n));

    // R7
    narrow_lwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cfg.narrow && !bus_as_n) |-> bus_lwr_n);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> !req_ready);

endmodule

bind ebc_bus_ctrl ebc_bus_ctrl_chk #(.AREA_BITS(AREA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_cs_n  (bus_cs_n),
    .bus_as_n  (bus_as_n),
    .bus_rd_n  (bus_rd_n),
    .bus_hwr_n (bus_hwr_n),
    .bus_lwr_n (bus_lwr_n),
    .state     (state),
    .cur_cfg   (cur_cfg)
);

// File: tb/tb_ebc_bus_ctrl.sv
`timescale 1ns/1ps
module tb_ebc_bus_ctrl;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_ready, req_write, done, cfg_we, bus_as_n;
    logic        bus_rd_n, bus_hwr_n, bus_lwr_n, bus_doe;
    logic [23:0] req_addr, bus_addr;
    logic [1:0]  req_be;
    logic [15:0] req_wdata, rdata, bus_dout, bus_din;
    logic [2:0]  cfg_area;
    logic [6:0]  cfg_wdata;
    logic [7:0]  bus_cs_n;

    ebc_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wdata(cfg_wdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
        .bus_hwr_n(bus_hwr_n), .bus_lwr_n(bus_lwr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    typedef struct {
        logic [15:0] rdata;
        logic        is_read;
        int          as_cnt, rd_cnt, hwr_cnt, lwr_cnt;
        logic [7:0]  cs_mask;
        logic [15:0] hi_first, hi_last, lo_last;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   m_narrow[8], m_slow[8], m_early[8], m_ext[8];
    int   m_waits[8];
    bit   finished = 0;

    function automatic logic [7:0] mem_b(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // external memory model
    always_comb begin
        if (m_narrow[bus_addr[23:21]]) bus_din = {mem_b(bus_addr), 8'h00};
        else bus_din = {mem_b({bus_addr[23:1], 1'b0}), mem_b({bus_addr[23:1], 1'b1})};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    int          as_c, cs_c, rd_c, hwr_c, lwr_c;
    logic [7:0]  cs_acc;
    logic [15:0] hi_f, hi_l, lo_l;
    bit          hi_seen, ready_err, doe_err;

    task automatic clr_acc();
        as_c = 0; cs_c = 0; rd_c = 0; hwr_c = 0; lwr_c = 0; cs_acc = 8'h00;
        hi_f = 16'hFFFF; hi_l = 16'hFFFF; lo_l = 16'hFFFF; hi_seen = 0;
    endtask

    initial clr_acc();

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!bus_as_n) begin
                as_c++;
                if (req_ready) ready_err = 1;
            end
            if (bus_cs_n != 8'hFF) cs_c++;
            cs_acc |= ~bus_cs_n;
            if (!bus_rd_n) rd_c++;
            if (!bus_hwr_n) begin
                hwr_c++;
                if (!hi_seen) hi_f = {bus_addr[7:0], bus_dout[15:8]};
                hi_seen = 1;
                hi_l = {bus_addr[7:0], bus_dout[15:8]};
            end
            if (!bus_lwr_n) begin
                lwr_c++;
                lo_l = {bus_addr[7:0], bus_dout[7:0]};
            end
            if ((!bus_hwr_n || !bus_lwr_n) && !bus_doe) doe_err = 1;
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R9", "done with nothing pending", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(as_c == e.as_cnt, "R3", {e.tag, " bus ticks"}, as_c, e.as_cnt);
                    chk(cs_c == e.as_cnt, "R2", {e.tag, " cs ticks"}, cs_c, e.as_cnt);
                    chk(cs_acc == e.cs_mask, "R2", {e.tag, " cs mask"}, cs_acc, e.cs_mask);
                    chk(rd_c == e.rd_cnt, "R4", {e.tag, " rd ticks"}, rd_c, e.rd_cnt);
                    chk(hwr_c == e.hwr_cnt, "R6", {e.tag, " hwr ticks"}, hwr_c, e.hwr_cnt);
                    chk(lwr_c == e.lwr_cnt, "R6", {e.tag, " lwr ticks"}, lwr_c, e.lwr_cnt);
                    if (e.is_read)
                        chk(rdata == e.rdata, "R9", {e.tag, " rdata"}, rdata, e.rdata);
                    else begin
                        chk(hi_f == e.hi_first, "R11", {e.tag, " first hi byte"}, hi_f, e.hi_first);
                        chk(hi_l == e.hi_last, "R11", {e.tag, " last hi byte"}, hi_l, e.hi_last);
                        chk(lo_l == e.lo_last, "R11", {e.tag, " lo byte"}, lo_l, e.lo_last);
                    end
                end
                clr_acc();
            end
        end
    end

    task automatic set_cfg(input int ar, input bit nar, input bit slw, input int w,
                           input bit erl, input bit ex);
        @(negedge clk);
        cfg_we = 1; cfg_area = 3'(ar); cfg_wdata = {ex, erl, 3'(w), slw, nar};
        @(negedge clk);
        cfg_we = 0;
        m_narrow[ar] = nar; m_slow[ar] = slw; m_waits[ar] = w; m_early[ar] = erl; m_ext[ar] = ex;
    endtask

    task automatic do_req(input logic [23:0] a, input bit wr, input logic [1:0] be,
                          input logic [15:0] wd, input string tag);
        exp_t e;
        int ar, acc, ph;
        ar  = int'(a[23:21]);
        acc = m_slow[ar] ? 2 * (3 + m_waits[ar]) : 4;
        ph  = (m_narrow[ar] && be == 2'b11) ? 2 : 1;
        e.as_cnt  = ph * (acc + (m_ext[ar] ? 4 : 0));
        e.rd_cnt  = wr ? 0 : ph * (acc - 1 - (m_early[ar] ? 1 : 0));
        e.hwr_cnt = (wr && (m_narrow[ar] || be[1])) ? ph * (acc - 1) : 0;
        e.lwr_cnt = (wr && !m_narrow[ar] && be[0]) ? acc - 1 : 0;
        e.cs_mask = 8'(1 << ar);
        e.is_read = !wr;
        e.rdata   = {be[1] ? mem_b({a[23:1], 1'b0}) : 8'h00,
                     be[0] ? mem_b({a[23:1], 1'b1}) : 8'h00};
        e.hi_first = 16'hFFFF; e.hi_last = 16'hFFFF; e.lo_last = 16'hFFFF;
        if (wr) begin
            if (m_narrow[ar]) begin
                if (be == 2'b11) begin
                    e.hi_first = {a[7:0], wd[15:8]};
                    e.hi_last  = {a[7:0] | 8'h01, wd[7:0]};
                end else begin
                    e.hi_first = {a[7:0], be[1] ? wd[15:8] : wd[7:0]};
                    e.hi_last  = e.hi_first;
                end
            end else begin
                if (be[1]) begin
                    e.hi_first = {a[7:0], wd[15:8]};
                    e.hi_last  = e.hi_first;
                end
                if (be[0]) e.lo_last = {a[7:0], wd[7:0]};
            end
        end
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_narrow[i] = 0; m_slow[i] = 1; m_waits[i] = 7; m_early[i] = 0; m_ext[i] = 0;
        end
        ready_err = 0; doe_err = 0;
        rst_n = 0; req_valid = 0; req_addr = '0; req_write = 0; req_be = 2'b00;
        req_wdata = '0; cfg_we = 0; cfg_area = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(bus_cs_n == 8'hFF, "R1", "cs idle", bus_cs_n, 8'hFF);
        chk({bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n} == 4'hF, "R1", "strobes idle",
            {bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n}, 4'hF);
        chk({bus_doe, done, req_ready} == 3'b001, "R1", "doe/done/ready",
            {bus_doe, done, req_ready}, 3'b001);

        // R1 default settings: 16-bit, long access, 7 waits
        do_req(24'h000010, 0, 2'b11, 16'h0, "R1 default read");
        do_req(24'hE00044, 1, 2'b11, 16'hA1B2, "R1 default write");

        // R3 short access ignores wait field
        set_cfg(1, 0, 0, 5, 0, 0);
        do_req(24'h200020, 0, 2'b11, 16'h0, "R3 short read");

        // R4 early release
        set_cfg(2, 0, 1, 2, 1, 0);
        do_req(24'h400032, 0, 2'b11, 16'h0, "R4 early read");

        // R5 extension, R6 lanes
        set_cfg(3, 0, 1, 0, 0, 1);
        do_req(24'h600050, 1, 2'b11, 16'hC3D4, "R5 ext word write");
        do_req(24'h600053, 1, 2'b01, 16'h77E5, "R6 odd byte write");
        do_req(24'h600060, 0, 2'b10, 16'h0, "R6 even byte read");
        do_req(24'h600061, 0, 2'b01, 16'h0, "R6 odd byte read");

        // R7, R8 narrow area
        set_cfg(4, 1, 0, 0, 0, 0);
        do_req(24'h800070, 0, 2'b11, 16'h0, "R8 split read");
        do_req(24'h800072, 1, 2'b11, 16'h9A8B, "R8 split write");
        do_req(24'h800075, 0, 2'b01, 16'h0, "R7 odd byte read");
        do_req(24'h800077, 1, 2'b01, 16'h12F6, "R7 odd byte write");
        do_req(24'h800078, 1, 2'b10, 16'h4D12, "R7 even byte write");

        // R5 R8 narrow, long, extended, early
        set_cfg(5, 1, 1, 1, 1, 1);
        do_req(24'hA00080, 0, 2'b11, 16'h0, "R5 narrow ext split read");

        // R10 write to area 1 during a busy cycle is dropped
        fork
            do_req(24'hC00090, 0, 2'b11, 16'h0, "R10 long read");
            begin
                repeat (4) @(negedge clk);
                cfg_we = 1; cfg_area = 3'd1; cfg_wdata = {1'b1, 1'b0, 3'd7, 1'b1, 1'b0};
                @(negedge clk);
                cfg_we = 0;
            end
        join
        do_req(24'h200024, 0, 2'b11, 16'h0, "R10 area1 still short");

        chk(!ready_err, "R9", "ready low while busy", ready_err, 0);
        chk(!doe_err, "R11", "doe with write strobe", doe_err, 0);
        chk(sb_q.size() == 0, "R8", "pending items", sb_q.size(), 0);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule